// File: doc/BRIEF.md
# Sequential Flash Prefetch Engine

This block sits between a processor's instruction fetch port and a slow flash array. The flash returns one 32-bit word (four code bytes) per access, and each access takes four core clock cycles. The engine keeps one private linear slot. The slot holds the tag, the data and a valid bit of the most recently completed flash word. The engine also keeps track of the single read that may be in flight. Each time a read completes, the engine at once starts the next sequential word. Straight-line code that consumes one byte per cycle therefore never waits.

Each cycle, a request is answered from one of three places, in this order: the linear slot, an external branch cache that reports a hit together with its data, or the flash word that completes in that same cycle. A request for the word already in flight stalls the core until that read lands, and the read is not restarted. Any other miss abandons the current read and starts a new one at the requested word. When a read that a miss started completes, a fill strobe offers the word to the branch cache. The cache storage itself lives outside this block.

Top module: `flash_prefetch`

## Requirements
- R1: After reset no flash read is active and the linear slot is invalid. The first request after reset misses and starts a flash read in the same cycle.
- R2: A miss is a request that is not served in its cycle and whose word is not in flight. On a miss, `rdy` is low and `fl_start` is high in the same cycle. `fl_addr` equals `req_addr[ADDR_W-1:2]`. `fl_abort` is high in that cycle only if a read is in progress and does not complete in that cycle.
- R3: A request whose word matches the valid linear slot gets `rdy` high in the same cycle, with the slot's data on `rd_data`. This holds even when `bc_hit` is high.
- R4: A request that misses the linear slot while `bc_hit` is high gets `rdy` high with `bc_data` on `rd_data`. It neither aborts nor starts a flash read.
- R5: A request for the word currently in flight keeps `rdy` low and raises neither `fl_start` nor `fl_abort` until `fl_done`. In the `fl_done` cycle, `rdy` is high and `rd_data` carries `fl_data`.
- R6: When a read completes and no miss occurs in that cycle, `fl_start` is high in the same cycle and `fl_addr` is the completed word plus one.
- R7: When a read that a miss started completes, `fill_valid` is high in that cycle, with the word address on `fill_addr` and the data on `fill_data`. Completions of sequential reads leave `fill_valid` low.
- R8: The linear slot becomes valid with the completed word when a read completes. It becomes invalid when a miss starts a read, and this clearing wins over a completion in the same cycle. Starting a sequential read does not clear it.
- R9: Once the first word has been served, a core that steps through consecutive byte addresses, one per cycle, is never stalled.
- R10: `rdy` is low in every cycle in which `req_valid` is low.
- R11: A request held unchanged is stalled for at most four consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core fetch request present |
| req_addr | input | ADDR_W | Byte address of the fetch |
| rdy | output | 1 | Requested word is available this cycle |
| rd_data | output | 32 | Word containing the requested byte |
| bc_hit | input | 1 | Branch cache holds the requested word |
| bc_data | input | 32 | Branch cache word for the request |
| fl_start | output | 1 | Begin a flash read |
| fl_addr | output | ADDR_W-2 | Word address of the read being started |
| fl_abort | output | 1 | Cancel the read in progress |
| fl_done | input | 1 | Read completes this cycle |
| fl_data | input | 32 | Flash word, valid with fl_done |
| fill_valid | output | 1 | Offer a miss-fetched word to the branch cache |
| fill_addr | output | ADDR_W-2 | Word address of the offered word |
| fill_data | output | 32 | Offered word |

## Verification
A stale or wrong linear tag shows up in the cycle of the next request that touches that word. Depending on the fault, `rdy` comes back high with the wrong data, or a needless `fl_start` and `fl_abort` pair appears. A lost in-flight address or demand flag shows up no later than the next `fl_done`. It appears as a wrong sequential `fl_addr`, a missing or spurious `fill_valid`, or a restart where a wait was due. A broken stall path shows up as a stall counted past four cycles on a held request, or as any stall during a straight-line run.

// File: rtl/pf_pkg.sv
// Shared types for the flash prefetch engine.
// Assumes: a flash word is 32 bits and holds four code bytes.
package pf_pkg;
    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 32;

    // Where the answer to the current request comes from
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LIN   = 2'd1,
        SRC_CACHE = 2'd2,
        SRC_FLASH = 2'd3
    } resp_src_e;
endpackage

// File: rtl/pf_lin_slot.sv
// Linear slot: one tag, one data word and a valid bit, all holding the
// last completed flash word. Assumes that a write and an invalidate
// arriving together leave the slot invalid.
module pf_lin_slot #(
    parameter int WA_W   = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inval,
    input  logic [WA_W-1:0]   look_tag,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    logic              valid_q;
    logic [WA_W-1:0]   tag_q;
    logic [DATA_W-1:0] data_q;

    // Capture a completed word, then let a demand restart clear validity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            if (wr_en) begin
                tag_q   <= wr_tag;
                data_q  <= wr_data;
                valid_q <= 1'b1;
            end
            if (inval) begin
                valid_q <= 1'b0;
            end
        end
    end

    // Tag compare against the requested word
    always_comb begin
        hit  = valid_q && (tag_q == look_tag);
        data = data_q;
    end
endmodule

// File: rtl/pf_fetch_ctl.sv
// Tracks the single flash read in flight: whether one is busy, its word
// address and whether a miss started it. Assumes that every abort comes
// with a new start, so an abort never leaves the engine idle.
module pf_fetch_ctl #(
    parameter int WA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WA_W-1:0] start_addr,
    input  logic            start_dem,
    input  logic            done,
    output logic            busy,
    output logic [WA_W-1:0] cur_addr,
    output logic            cur_dem
);
    logic            busy_q;
    logic [WA_W-1:0] addr_q;
    logic            dem_q;

    // Load a new read on start, drop busy when a read ends with no successor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            dem_q  <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            addr_q <= start_addr;
            dem_q  <= start_dem;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // Expose the tracked state
    always_comb begin
        busy     = busy_q;
        cur_addr = addr_q;
        cur_dem  = dem_q;
    end
endmodule

// File: rtl/pf_resp_sel.sv
// Picks the source that answers the current request, in priority order:
// linear slot, then branch cache, then a flash word completing this cycle.
// Purely combinational.
module pf_resp_sel
    import pf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          req_valid,
    input  logic          lin_hit,
    input  logic [DW-1:0] lin_data,
    input  logic          bc_hit,
    input  logic [DW-1:0] bc_data,
    input  logic          fly_match,
    input  logic          fl_done,
    input  logic [DW-1:0] fl_data,
    output resp_src_e     src,
    output logic [DW-1:0] data
);
    // Priority select of the answering source
    always_comb begin
        src  = SRC_NONE;
        data = '0;
        if (req_valid) begin
            if (lin_hit) begin
                src  = SRC_LIN;
                data = lin_data;
            end else if (bc_hit) begin
                src  = SRC_CACHE;
                data = bc_data;
            end else if (fly_match && fl_done) begin
                src  = SRC_FLASH;
                data = fl_data;
            end
        end
    end
endmodule

// File: rtl/flash_prefetch.sv
// Sequential flash prefetch engine. It serves core fetches from the linear
// slot, from a branch cache hit or from a completing flash read. It waits
// on a word already in flight, restarts on any other miss, and runs one
// word ahead after every completion. Assumes the flash raises fl_done only
// while a read is active, and accepts a start and an abort in the same
// cycle.
module flash_prefetch
    import pf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    output logic                             rdy,
    output logic [31:0]                      rd_data,
    input  logic                             bc_hit,
    input  logic [31:0]                      bc_data,
    output logic                             fl_start,
    output logic [ADDR_W-$clog2(4)-1:0]      fl_addr,
    output logic                             fl_abort,
    input  logic                             fl_done,
    input  logic [31:0]                      fl_data,
    output logic                             fill_valid,
    output logic [ADDR_W-$clog2(4)-1:0]      fill_addr,
    output logic [31:0]                      fill_data
);
    localparam int OFF_W = $clog2(WORD_BYTES);
    localparam int WA_W  = ADDR_W - OFF_W;

    logic [WA_W-1:0]   req_word;
    logic              lin_hit;
    logic [DATA_W-1:0] lin_data;
    logic              busy;
    logic [WA_W-1:0]   cur_addr;
    logic              cur_dem;
    logic              done_eff;
    logic              fly_match;
    logic              miss;
    resp_src_e         src;
    logic [DATA_W-1:0] sel_data;

    // Split the byte address into a word address
    always_comb begin
        req_word = req_addr[ADDR_W-1:OFF_W];
    end

    pf_lin_slot #(.WA_W(WA_W), .DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (done_eff),
        .wr_tag   (cur_addr),
        .wr_data  (fl_data),
        .inval    (miss),
        .look_tag (req_word),
        .hit      (lin_hit),
        .data     (lin_data)
    );

    pf_fetch_ctl #(.WA_W(WA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fl_start),
        .start_addr (fl_addr),
        .start_dem  (miss),
        .done       (done_eff),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .cur_dem    (cur_dem)
    );

    pf_resp_sel #(.DW(DATA_W)) u_sel (
        .req_valid (req_valid),
        .lin_hit   (lin_hit),
        .lin_data  (lin_data),
        .bc_hit    (bc_hit),
        .bc_data   (bc_data),
        .fly_match (fly_match),
        .fl_done   (done_eff),
        .fl_data   (fl_data),
        .src       (src),
        .data      (sel_data)
    );

    // Classify the request: in flight, served, or a miss that restarts
    always_comb begin
        done_eff  = fl_done && busy;
        fly_match = req_valid && busy && (cur_addr == req_word);
        rdy       = (src != SRC_NONE);
        rd_data   = sel_data;
        miss      = req_valid && !rdy && !fly_match;
    end

    // Flash control: demand restart wins over the sequential next word
    always_comb begin
        fl_start = miss || done_eff;
        fl_addr  = miss ? req_word : cur_addr + 1'b1;
        fl_abort = miss && busy && !done_eff;
    end

    // Offer words fetched on a miss to the branch cache
    always_comb begin
        fill_valid = done_eff && cur_dem;
        fill_addr  = cur_addr;
        fill_data  = fl_data;
    end
endmodule

// File: rtl/pf_checker.sv
// Port-level properties of the prefetch engine, bound to every instance.
// A counter measures how long a held request has been stalling.
module pf_checker #(
    parameter int ADDR_W = 16,
    parameter int LAT    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rdy,
    input logic              fl_start,
    input logic              fl_abort,
    input logic              fl_done,
    input logic              fill_valid
);
    logic              prev_stall;
    logic [ADDR_W-1:0] prev_addr;
    logic [7:0]        run_q;
    logic              held;

    always_comb begin
        held = prev_stall && (prev_addr == req_addr);
    end

    // Count consecutive stalled cycles of one unchanged request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_stall <= 1'b0;
            prev_addr  <= '0;
            run_q      <= '0;
        end else begin
            prev_stall <= req_valid && !rdy;
            prev_addr  <= req_addr;
            if (req_valid && !rdy) begin
                run_q <= held ? run_q + 8'd1 : 8'd1;
            end else begin
                run_q <= '0;
            end
        end
    end

    // R10
    no_ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !rdy);

    // R2
    abort_with_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_abort |-> (fl_start && !fl_done));

    // R6
    next_read_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |-> fl_start);

    // R7
    fill_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> fl_done);

    // R11
    stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rdy && held) |-> (run_q < LAT));
endmodule

bind flash_prefetch pf_checker #(.ADDR_W(ADDR_W), .LAT(4)) i_pf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rdy        (rdy),
    .fl_start   (fl_start),
    .fl_abort   (fl_abort),
    .fl_done    (fl_done),
    .fill_valid (fill_valid)
);

// File: tb/test_flash_prefetch.sv
// Self-checking bench: a flash model with a fixed four-cycle latency, a
// cycle model of the requirements, directed corner cases and a seeded
// random core.
module test_flash_prefetch;
    localparam int AW = 16;
    localparam int WW = AW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          bc_hit = 1'b0;
    logic [31:0]   bc_data = '0;
    logic          rdy, fl_start, fl_abort, fill_valid;
    logic [31:0]   rd_data, fill_data, fl_data;
    logic [WW-1:0] fl_addr, fill_addr;
    logic          fl_done;

    int checks = 0;
    int fails  = 0;

    // flash model state
    logic          fm_busy = 1'b0;
    logic [1:0]    fm_cnt = '0;
    logic [WW-1:0] fm_addr = '0;
    // requirement model state
    logic          m_lv = 1'b0, m_busy = 1'b0, m_dem = 1'b0;
    logic [WW-1:0] m_lt = '0, m_a = '0;
    logic [31:0]   m_ld = '0;
    // last observed values
    logic          o_rdy, o_start, o_abort, o_fill;
    logic [WW-1:0] o_addr, o_faddr;
    logic [31:0]   o_data;

    always #5 clk = ~clk;

    function automatic logic [31:0] fdata(input logic [WW-1:0] w);
        return {2'b10, w[5:0], w[13:6], ~w[7:0], w[7:0] ^ 8'h5A};
    endfunction

    assign fl_done = fm_busy && (fm_cnt == 2'd0);
    assign fl_data = fm_busy ? fdata(fm_addr) : 32'h0;

    flash_prefetch #(.ADDR_W(AW)) i_flash_prefetch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rdy(rdy), .rd_data(rd_data), .bc_hit(bc_hit), .bc_data(bc_data),
        .fl_start(fl_start), .fl_addr(fl_addr), .fl_abort(fl_abort),
        .fl_done(fl_done), .fl_data(fl_data), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_data(fill_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One core cycle: drive, compare against the model, advance the model
    task automatic cycle(input logic rv, input logic [AW-1:0] ra, input logic bh,
                         input logic [31:0] bd);
        logic [WW-1:0] w;
        logic lh, dn, fly, e_rdy, miss, e_start, e_abort, e_fill;
        logic [31:0] e_data;
        logic [WW-1:0] e_addr;
        string tag;
        @(negedge clk);
        req_valid = rv; req_addr = ra; bc_hit = bh; bc_data = bd;
        #1;
        w       = ra[AW-1:2];
        lh      = m_lv && (m_lt == w);
        dn      = m_busy && fl_done;
        fly     = rv && m_busy && (m_a == w);
        e_rdy   = rv && (lh || bh || (fly && dn));
        e_data  = lh ? m_ld : (bh ? bd : fl_data);
        miss    = rv && !e_rdy && !fly;
        e_start = miss || dn;
        e_addr  = miss ? w : m_a + 1'b1;
        e_abort = miss && m_busy && !dn;
        e_fill  = dn && m_dem;
        tag = !rv ? "R10" : (lh ? "R3" : (bh ? "R4" : (fly ? "R5" : "R2")));
        chk(rdy === e_rdy, tag, {31'd0, rdy}, {31'd0, e_rdy});
        if (e_rdy) chk(rd_data === e_data, tag, rd_data, e_data);
        chk(fl_start === e_start, miss ? "R2" : "R6", {31'd0, fl_start}, {31'd0, e_start});
        if (e_start) chk(fl_addr === e_addr, miss ? "R2" : "R6", {18'd0, fl_addr}, {18'd0, e_addr});
        chk(fl_abort === e_abort, "R2", {31'd0, fl_abort}, {31'd0, e_abort});
        chk(fill_valid === e_fill, "R7", {31'd0, fill_valid}, {31'd0, e_fill});
        if (e_fill) chk(fill_addr === m_a && fill_data === fl_data, "R7",
                        {18'd0, fill_addr}, {18'd0, m_a});
        o_rdy = rdy; o_start = fl_start; o_abort = fl_abort; o_fill = fill_valid;
        o_addr = fl_addr; o_faddr = fill_addr; o_data = rd_data;
        @(posedge clk);
        #1;
        if (dn) begin m_lt = m_a; m_ld = fdata(m_a); m_lv = 1'b1; end
        if (miss) m_lv = 1'b0;
        if (e_start) begin m_busy = 1'b1; m_a = e_addr; m_dem = miss; end
        else if (dn) m_busy = 1'b0;
        if (e_start) begin fm_busy = 1'b1; fm_cnt = 2'd3; fm_addr = e_addr; end
        else if (fm_busy) begin
            if (fm_cnt == 2'd0) fm_busy = 1'b0; else fm_cnt = fm_cnt - 2'd1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] pc;
        int stalls;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: idle after reset, then a cold request misses
        cycle(1'b0, '0, 1'b0, '0);
        chk(!o_rdy && !o_start, "R1", {31'd0, o_start}, 32'd0);
        cycle(1'b1, 16'h0100, 1'b0, '0);
        chk(o_start && !o_rdy && o_addr == 14'h040, "R1", {18'd0, o_addr}, 32'h40);

        // R11: the held miss is served after exactly four stalled cycles
        stalls = 1;
        for (int i = 0; i < 8 && !o_rdy; i++) begin
            cycle(1'b1, 16'h0100, 1'b0, '0);
            if (!o_rdy) stalls++;
        end
        chk(stalls == 4, "R11", stalls, 32'd4);

        // R9: straight-line run without stalls
        pc = 16'h0101; stalls = 0;
        for (int i = 0; i < 40; i++) begin
            cycle(1'b1, pc, 1'b0, '0);
            if (o_rdy) pc++; else stalls++;
        end
        chk(stalls == 0, "R9", stalls, 32'd0);

        // R3: the linear slot wins over a cache hit
        cycle(1'b1, 16'h0129, 1'b1, 32'hDEADBEEF);
        chk(o_rdy && o_data == fdata(14'h04A), "R3", o_data, fdata(14'h04A));

        // R5: a request for the in-flight word waits without a restart
        stalls = 0;
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, 16'h012C, 1'b0, '0);
            if (!o_rdy) begin
                stalls++;
                chk(!o_abort && !o_start, "R5", {31'd0, o_abort}, 32'd0);
            end else break;
        end
        chk(stalls == 2 && o_data == fdata(14'h04B), "R5", stalls, 32'd2);

        // R4: a cache hit is served and the prefetch keeps running
        cycle(1'b1, 16'h0400, 1'b1, 32'h12345678);
        chk(o_rdy && o_data == 32'h12345678 && !o_abort && !o_start, "R4",
            o_data, 32'h12345678);

        // R2: a miss during a prefetch aborts it and restarts
        cycle(1'b1, 16'h0800, 1'b0, '0);
        chk(o_start && o_abort && o_addr == 14'h200, "R2", {18'd0, o_addr}, 32'h200);

        // R8: the demand restart has invalidated the slot's word
        cycle(1'b1, 16'h012D, 1'b0, '0);
        chk(!o_rdy && o_start && o_addr == 14'h04B, "R8", {31'd0, o_rdy}, 32'd0);
        for (int i = 0; i < 6 && !o_rdy; i++) cycle(1'b1, 16'h012D, 1'b0, '0);
        // R7: the completed demand read is offered to the cache
        chk(o_rdy && o_fill && o_faddr == 14'h04B, "R7", {18'd0, o_faddr}, 32'h4B);

        // R6 and R7: a sequential completion starts the next word without a fill
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, '0, 1'b0, '0);
            chk(!o_fill, "R7", {31'd0, o_fill}, 32'd0);
            if (o_start) chk(o_addr == 14'h04D, "R6", {18'd0, o_addr}, 32'h4D);
        end

        // Random core: mostly sequential, jumps near and far, random cache hits
        pc = 16'h0200;
        for (int i = 0; i < 3000; i++) begin
            logic rv, bh;
            rv = ($urandom % 10) != 0;
            bh = ($urandom % 8) == 0;
            cycle(rv, pc, bh, $urandom);
            if (o_rdy) begin
                case ($urandom % 12)
                    0: pc = pc + 16'(($urandom % 32) * 4) - 16'd48;
                    1: pc = 16'($urandom % 4096);
                    default: pc = pc + 16'd1;
                endcase
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule